// File: doc/BRIEF.md
# Multi-slope integrating converter sequencer

This block is the digital sequencer of a fast-slow integrating analog-to-digital converter. It divides the system clock by four to form an internal tick. On every tick it moves a conversion through zeroing, signal integration and reference deintegration, and drives the strobes that close the analog switches. It times the coarse and fine deintegration slopes from the comparator, derives the sign and the overrange flag, and presents a signed magnitude result together with a busy status.

A conversion is 1280 ticks long. Its timing is taken from a circular phase position: 0–245 zeroing, 246–501 signal integration, 502–1279 deintegration. A conversion enters that circle at position 183 and leaves after one full turn. As a result, busy spans the whole deintegration plus the first 58 zeroing ticks of the next turn, and 125 ticks remain after busy falls. In demand mode a falling edge on an active-low start strobe launches a conversion. In continuous mode conversions follow each other with no gap.

Top module: `msadc_sequencer`

## Requirements
- R1: All phase timing advances only on the internal tick, which occurs once every 4 clock cycles. Signal integration therefore lasts 256 × 4 clocks.
- R2: A conversion takes 1280 ticks: 246 zeroing, 256 signal integration and 778 deintegration. In continuous mode, consecutive busy rising edges are 1280 ticks apart. At most one of the zero, signal, fast and slow switch strobes is active at a time.
- R3: For an input of magnitude r below 32768, the fast slope runs while the comparator agrees with the stored sign, for at most 512 ticks. The fine slope then runs for at most 64 ticks. The reported magnitude is coarse × 64 + fine = r, and the overrange flag is 0.
- R4: The comparator level (1 = positive) at the last signal-integration tick is stored as the sign bit. It is also driven on refNeg to select the reference direction.
- R5: If the comparator still agrees after all 512 fast ticks, the overrange flag is set. The magnitude then holds only the extra count from the slow and overrange windows, capped at 190, with every upper bit zero.
- R6: Busy rises at the first deintegration tick and stays high for exactly 836 ticks (3344 clocks).
- R7: In demand mode, only a falling edge of wrN starts a conversion, and busy falls 1155 ticks after the start. Holding wrN low starts nothing further.
- R8: Start edges that arrive in the first 1100 ticks of a running conversion are ignored. A later edge is held and starts the next conversion as soon as the current one ends.
- R9: In continuous mode the result is valid for 443.5 ticks (1774 clocks) after busy falls. It is cleared half a tick before busy rises again.
- R10: Synchronous reset leaves the block idle with busy low, no valid result, and only the zero strobe active.
- R11: In demand mode, a latched result stays valid and unchanged until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrN | input | 1 | Qualified start strobe, active low, edge-sensitive |
| contMode | input | 1 | 1 = continuous conversions, 0 = demand |
| cmpIn | input | 1 | Comparator output, 1 when integrator is positive |
| zeroSw | output | 1 | Zeroing switch strobe (also active while idle) |
| sigSw | output | 1 | Signal integration switch strobe |
| fastSw | output | 1 | Full-size reference slope strobe |
| slowSw | output | 1 | 1/64 reference slope strobe (fine and overrange) |
| refNeg | output | 1 | Stored sign, selects reference direction |
| busy | output | 1 | Conversion status |
| resultValid | output | 1 | Result registers hold a finished conversion |
| resSign | output | 1 | Sign of result, 1 = positive |
| resOver | output | 1 | Overrange flag |
| resMag | output | 15 | Magnitude, or extra count when overrange |

## Verification
The assertions assume that the comparator changes state at most once per fast or fine window, as a real integrator ramping toward zero would. They also assume that wrN and contMode are synchronous to clk. The bench meets both assumptions. It drives cmpIn at falling clock edges from a model of the integrator for a fixed input held across each conversion. It changes the strobe and the mode only between rising edges, and it switches mode only while the block is idle.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
  // Control-to-datapath strobes, one set per clock
  typedef struct packed {
    logic tick;       // internal divided tick
    logic polSample;  // last signal tick: capture sign, arm counters
    logic fastWin;    // inside fast-slope window
    logic slowWin;    // inside in-range fine window
    logic fineWin;    // inside fine plus overrange window
    logic latchRes;   // busy falls on this edge
    logic clearRes;   // drop result valid
  } seqCtl_t;
endpackage

// File: rtl/msadc_ctrl.sv
module msadc_ctrl
  import msadc_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int ZERO_T  = 246,
  parameter int SIG_T   = 256,
  parameter int DEINT_T = 778,
  parameter int FAST_T  = 512,
  parameter int SLOW_T  = 64,
  parameter int OVR_T   = 192,
  parameter int BUSY_T  = 836,
  parameter int REST_T  = 125,
  parameter int LOCK_T  = 1100
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wrN,
  input  logic    contMode,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    zeroSw,
  output logic    sigSw
);
  localparam int CYCLE       = ZERO_T + SIG_T + DEINT_T;
  localparam int CW          = $clog2(CYCLE);
  localparam int PW          = $clog2(DIV);
  localparam int DEINT_START = ZERO_T + SIG_T;
  localparam int FINE_START  = DEINT_START + FAST_T;
  localparam int BUSY_END    = DEINT_START + BUSY_T - CYCLE;
  localparam int START_OFF   = BUSY_END + REST_T;

  logic [PW-1:0] pre;
  logic [CW-1:0] cyc, el;
  logic running, pending, wrPrevN;
  logic tick, wrEdge, accept, wantStart, lastTick, startNow;

  assign tick      = (pre == PW'(DIV - 1));
  assign wrEdge    = wrPrevN & ~wrN;
  assign accept    = wrEdge & ~contMode & (~running | (el >= CW'(LOCK_T)));
  assign wantStart = pending | accept | contMode;
  assign lastTick  = running & (el == CW'(CYCLE - 1));
  assign startNow  = tick & wantStart & (~running | lastTick);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0; cyc <= '0; el <= '0;
      running <= 1'b0; pending <= 1'b0; wrPrevN <= 1'b1; busy <= 1'b0;
    end else begin
      wrPrevN <= wrN;
      pre     <= tick ? '0 : pre + 1'b1;
      pending <= startNow ? 1'b0 : (pending | accept);
      if (tick) begin
        if (startNow) begin
          running <= 1'b1;
          el      <= '0;
          cyc     <= CW'(START_OFF);
        end else if (lastTick) begin
          running <= 1'b0;
        end else if (running) begin
          el  <= el + 1'b1;
          cyc <= (cyc == CW'(CYCLE - 1)) ? '0 : cyc + 1'b1;
        end
        if (running && cyc == CW'(DEINT_START - 1)) busy <= 1'b1;
        if (running && cyc == CW'(BUSY_END - 1))    busy <= 1'b0;
      end
    end
  end

  assign zeroSw = ~running | (cyc < CW'(ZERO_T));
  assign sigSw  = running & (cyc >= CW'(ZERO_T)) & (cyc < CW'(DEINT_START));

  always_comb begin
    ctl.tick      = tick;
    ctl.polSample = tick & running & (cyc == CW'(DEINT_START - 1));
    ctl.fastWin   = running & (cyc >= CW'(DEINT_START)) & (cyc < CW'(FINE_START));
    ctl.slowWin   = running & (cyc >= CW'(FINE_START)) & (cyc < CW'(FINE_START + SLOW_T));
    ctl.fineWin   = running & (cyc >= CW'(FINE_START)) & (cyc < CW'(FINE_START + SLOW_T + OVR_T));
    ctl.latchRes  = tick & running & (cyc == CW'(BUSY_END - 1));
    ctl.clearRes  = (startNow & ~contMode) |
                    (contMode & running & (cyc == CW'(DEINT_START - 1)) & (pre == PW'(DIV / 2 - 1)));
  end
endmodule

// File: rtl/msadc_datapath.sv
module msadc_datapath
  import msadc_pkg::*;
#(
  parameter int FAST_T  = 512,
  parameter int SLOW_T  = 64,
  parameter int OVR_T   = 192,
  parameter int OVR_CAP = 190,
  localparam int COARSE_W = $clog2(FAST_T),
  localparam int SLOW_W   = $clog2(SLOW_T),
  localparam int FINE_W   = $clog2(SLOW_T + OVR_T),
  localparam int MAG_W    = COARSE_W + SLOW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  seqCtl_t          ctl,
  input  logic             cmpIn,
  output logic             fastSw,
  output logic             slowSw,
  output logic             refNeg,
  output logic             resultValid,
  output logic             resSign,
  output logic             resOver,
  output logic [MAG_W-1:0] resMag
);
  logic pol, fastAct, fineAct, agree, fineGate;
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine, fineCap;

  assign agree    = (cmpIn == pol);
  // in range the fine slope gets the short window; overrange extends it
  assign fineGate = ctl.fineWin & (fastAct | ctl.slowWin);
  assign fineCap  = fastAct ? FINE_W'(OVR_CAP) : FINE_W'(SLOW_T - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= 1'b0; fastAct <= 1'b0; fineAct <= 1'b0;
      coarse <= '0; fine <= '0;
      resultValid <= 1'b0; resSign <= 1'b0; resOver <= 1'b0; resMag <= '0;
    end else begin
      if (ctl.polSample) begin
        pol <= cmpIn; fastAct <= 1'b1; fineAct <= 1'b1;
        coarse <= '0; fine <= '0;
      end else if (ctl.tick) begin
        if (ctl.fastWin && fastAct) begin
          if (agree) coarse <= coarse + 1'b1;
          else       fastAct <= 1'b0;
        end
        if (fineGate && fineAct) begin
          if (agree && fine < fineCap) fine <= fine + 1'b1;
          else                         fineAct <= 1'b0;
        end
      end
      if (ctl.clearRes) resultValid <= 1'b0;
      if (ctl.latchRes) begin
        resultValid <= 1'b1;
        resSign     <= pol;
        resOver     <= fastAct;
        resMag      <= fastAct ? {{(MAG_W-FINE_W){1'b0}}, fine} : {coarse, fine[SLOW_W-1:0]};
      end
    end
  end

  assign fastSw = ctl.fastWin & fastAct;
  assign slowSw = fineGate & fineAct;
  assign refNeg = pol;
endmodule

// File: rtl/msadc_sequencer.sv
module msadc_sequencer
  import msadc_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int ZERO_T  = 246,
  parameter int SIG_T   = 256,
  parameter int DEINT_T = 778,
  parameter int FAST_T  = 512,
  parameter int SLOW_T  = 64,
  parameter int OVR_T   = 192,
  parameter int OVR_CAP = 190,
  parameter int BUSY_T  = 836,
  parameter int REST_T  = 125,
  parameter int LOCK_T  = 1100,
  localparam int MAG_W  = $clog2(FAST_T) + $clog2(SLOW_T)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrN,
  input  logic             contMode,
  input  logic             cmpIn,
  output logic             zeroSw,
  output logic             sigSw,
  output logic             fastSw,
  output logic             slowSw,
  output logic             refNeg,
  output logic             busy,
  output logic             resultValid,
  output logic             resSign,
  output logic             resOver,
  output logic [MAG_W-1:0] resMag
);
  seqCtl_t ctl;
  logic    tick;

  assign tick = ctl.tick;

  msadc_ctrl #(
    .DIV(DIV), .ZERO_T(ZERO_T), .SIG_T(SIG_T), .DEINT_T(DEINT_T),
    .FAST_T(FAST_T), .SLOW_T(SLOW_T), .OVR_T(OVR_T), .BUSY_T(BUSY_T),
    .REST_T(REST_T), .LOCK_T(LOCK_T)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrN(wrN), .contMode(contMode),
    .ctl(ctl), .busy(busy), .zeroSw(zeroSw), .sigSw(sigSw)
  );

  msadc_datapath #(
    .FAST_T(FAST_T), .SLOW_T(SLOW_T), .OVR_T(OVR_T), .OVR_CAP(OVR_CAP)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .cmpIn(cmpIn),
    .fastSw(fastSw), .slowSw(slowSw), .refNeg(refNeg),
    .resultValid(resultValid), .resSign(resSign), .resOver(resOver), .resMag(resMag)
  );
endmodule

// File: rtl/msadc_checker.sv
module msadc_checker #(
  parameter int BUSY_CLKS = 3344,
  parameter int OVR_CAP   = 190,
  parameter int MAG_W     = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             busy,
  input logic             zeroSw,
  input logic             sigSw,
  input logic             fastSw,
  input logic             slowSw,
  input logic             resultValid,
  input logic             resSign,
  input logic             resOver,
  input logic [MAG_W-1:0] resMag
);
  logic [31:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst)       busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= '0;
  end

  // R1: busy only moves on the edge after a tick
  p_tick_paced_r1: assert property (@(posedge clk) disable iff (rst)
    (busy != $past(busy)) |-> $past(tick));

  // R2: switch strobes never overlap
  p_sw_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({zeroSw, sigSw, fastSw, slowSw}));

  // R3: reference slopes only while busy
  p_slopes_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (fastSw || slowSw) |-> busy);

  // R5: overrange extra count stays within its cap
  p_over_cap_r5: assert property (@(posedge clk) disable iff (rst)
    (resultValid && resOver) |-> (resMag <= MAG_W'(OVR_CAP)));

  // R6: busy pulse length exact; signal integration never overlaps busy
  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busyCnt == BUSY_CLKS));

  p_sig_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    sigSw |-> !busy);

  // R11: a valid result does not change underneath the reader
  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (resultValid && $past(resultValid)) |-> $stable({resSign, resOver, resMag}));
endmodule

bind msadc_sequencer msadc_checker #(
  .BUSY_CLKS(BUSY_T * DIV), .OVR_CAP(OVR_CAP), .MAG_W(MAG_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .busy(busy), .zeroSw(zeroSw),
  .sigSw(sigSw), .fastSw(fastSw), .slowSw(slowSw), .resultValid(resultValid),
  .resSign(resSign), .resOver(resOver), .resMag(resMag)
);

// File: tb/sim_msadc_sequencer.sv
`timescale 1ns/1ps
module sim_msadc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CLKS    = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrN = 1'b1;
  logic contMode = 1'b0;
  logic cmpIn = 1'b1;
  logic zeroSw, sigSw, fastSw, slowSw, refNeg, busy, resultValid, resSign, resOver;
  logic [14:0] resMag;

  always #(CLK_PERIOD/2) clk = ~clk;

  msadc_sequencer u0 (
    .clk(clk), .rst(rst), .wrN(wrN), .contMode(contMode), .cmpIn(cmpIn),
    .zeroSw(zeroSw), .sigSw(sigSw), .fastSw(fastSw), .slowSw(slowSw), .refNeg(refNeg),
    .busy(busy), .resultValid(resultValid), .resSign(resSign), .resOver(resOver),
    .resMag(resMag)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;
  int vin = 0;

  // expected result from the requirements
  function automatic bit expSign(int v); return v >= 0; endfunction
  function automatic bit expOver(int v);
    int r; r = (v < 0) ? -v : v; return r >= 32768;
  endfunction
  function automatic int expMag(int v);
    int r; r = (v < 0) ? -v : v;
    if (r < 32768) return r;
    return (r - 32768 > 190) ? 190 : r - 32768;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: ticks since conversion start
  int  mPre = 0, mS = 0;
  bit  mRun = 0, mPend = 0, mWrPrev = 1, mBusy = 0, mValid = 0, mSign = 0, mOver = 0;
  int  mMag = 0;
  always @(posedge clk) begin
    if (rst) begin
      mPre = 0; mS = 0; mRun = 0; mPend = 0; mWrPrev = 1;
      mBusy = 0; mValid = 0; mSign = 0; mOver = 0; mMag = 0;
    end else begin
      bit tk, acc, st, last;
      tk   = (mPre == 3);
      acc  = mWrPrev && !wrN && !contMode && (!mRun || mS >= 1100);
      last = mRun && mS == 1279;
      st   = tk && (mPend || acc || contMode) && (!mRun || last);
      if (contMode && mRun && mS == 318 && mPre == 1) mValid = 0;
      if (st && !contMode) mValid = 0;
      if (tk && mRun && mS == 318) mBusy = 1;
      if (tk && mRun && mS == 1154) begin
        mBusy = 0; mValid = 1;
        mSign = expSign(vin); mOver = expOver(vin); mMag = expMag(vin);
      end
      if (tk) begin
        if (st) begin mRun = 1; mS = 0; end
        else if (last) mRun = 0;
        else if (mRun) mS++;
      end
      mPend = st ? 0 : (mPend || acc);
      mWrPrev = wrN;
      mPre = (mPre + 1) % 4;
    end
  end

  // integrator model drives the comparator
  always @(negedge clk) begin
    int cyc, r; bit pol, agree;
    r = (vin < 0) ? -vin : vin;
    pol = (vin >= 0);
    cyc = (183 + mS) % 1280;
    if (mRun && cyc >= 502 && cyc < 1014) begin
      agree = (cyc - 502) < (r / 64);
      cmpIn <= agree ? pol : ~pol;
    end else if (mRun && cyc >= 1014 && cyc < 1270) begin
      agree = (r >= 32768) ? ((cyc - 1014) < (r - 32768)) : ((cyc - 1014) < (r % 64));
      cmpIn <= agree ? pol : ~pol;
    end else cmpIn <= pol;
  end

  // per-clock comparison and measurements
  int clkNo = 0, busyLen = 0, lastBusyLen = 0, sigLen = 0, lastSigLen = 0;
  int validLen = 0, lastValidLen = 0, riseCnt = 0, lastRise = 0, riseGap = 0, lastFall = 0;
  bit pBusy = 0, pSig = 0, pValid = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit mSig, ok;
      mSig = mRun && mS >= 63 && mS <= 318;
      ok = (busy === mBusy) && (resultValid === mValid) && (sigSw === mSig);
      if (mValid && ok) ok = (resSign === mSign) && (resOver === mOver) && (int'(resMag) == mMag);
      check(ok, "R2 per-clock model", {busy, resultValid, sigSw}, {mBusy, mValid, mSig});
      if (busy) busyLen++;
      else if (pBusy) begin lastBusyLen = busyLen; busyLen = 0; lastFall = clkNo; end
      if (busy && !pBusy) begin riseCnt++; riseGap = clkNo - lastRise; lastRise = clkNo; end
      if (sigSw) sigLen++;
      else if (pSig) begin lastSigLen = sigLen; sigLen = 0; end
      if (resultValid) validLen++;
      else if (pValid) begin lastValidLen = validLen; validLen = 0; end
      pBusy = busy; pSig = sigSw; pValid = resultValid;
      clkNo++;
    end
  end

  task automatic ticks(int n); repeat (n * 4) @(negedge clk); endtask
  task automatic pulseWr();
    @(negedge clk); wrN = 1'b0; repeat (6) @(negedge clk); wrN = 1'b1;
  endtask

  task automatic convert(int v, string tag);
    vin = v; pulseWr(); ticks(1290);
    check(resultValid === 1'b1, tag, resultValid, 1);
    check(resSign === expSign(v), tag, resSign, expSign(v));
    check(resOver === expOver(v), tag, resOver, expOver(v));
    check(int'(resMag) == expMag(v), tag, resMag, expMag(v));
  endtask

  initial begin
    int edgeAt, rises;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(busy === 1'b0, "R10 busy", busy, 0);
    check(resultValid === 1'b0, "R10 valid", resultValid, 0);
    check(zeroSw === 1'b1 && sigSw === 1'b0 && fastSw === 1'b0 && slowSw === 1'b0,
          "R10 strobes", {zeroSw, sigSw, fastSw, slowSw}, 8);

    // R7 latency from start edge to busy fall
    vin = 1234;
    @(negedge clk); edgeAt = clkNo; wrN = 1'b0; repeat (6) @(negedge clk); wrN = 1'b1;
    ticks(1290);
    check(lastFall - edgeAt >= 4620 && lastFall - edgeAt <= 4625, "R7 latency", lastFall - edgeAt, 4620);
    check(lastBusyLen == 3344, "R6 busy length", lastBusyLen, 3344);
    check(lastSigLen == 256 * 4, "R1 signal integration clocks", lastSigLen, 1024);
    check(int'(resMag) == 1234 && resOver == 1'b0, "R3 magnitude 1234", resMag, 1234);

    convert(-20000, "R4 negative");
    check(refNeg === 1'b0, "R4 reference direction", refNeg, 0);
    convert(0, "R3 zero");
    convert(32767, "R3 full scale");
    convert(-5, "R4 small negative");
    convert(32768, "R5 just over");
    convert(32768 + 99, "R5 over 99");
    convert(32768 + 250, "R5 over capped");
    convert(-(32768 + 5), "R5 negative over");

    // R11 demand result held
    ticks(600);
    check(resultValid === 1'b1 && int'(resMag) == 5 && resOver === 1'b1, "R11 held", resMag, 5);

    // R7 holding the strobe low starts nothing more
    vin = 777; rises = riseCnt;
    @(negedge clk); wrN = 1'b0;
    ticks(1290 + 1400);
    check(riseCnt - rises == 1, "R7 hold low", riseCnt - rises, 1);
    @(negedge clk); wrN = 1'b1; ticks(2);

    // R8 early edge ignored
    rises = riseCnt;
    pulseWr(); ticks(500); pulseWr(); ticks(2700);
    check(riseCnt - rises == 1, "R8 early edge ignored", riseCnt - rises, 1);

    // R8 late edge queued, next conversion back to back
    rises = riseCnt;
    pulseWr(); ticks(1150); pulseWr(); ticks(1280 + 1300);
    check(riseCnt - rises == 2, "R8 late edge queued", riseCnt - rises, 2);
    check(riseGap == 1280 * 4, "R8 back-to-back gap", riseGap, 5120);

    // R9 continuous mode
    vin = -4321;
    @(negedge clk); contMode = 1'b1;
    ticks(1280 * 3 + 400);
    check(lastValidLen == 1774, "R9 valid window", lastValidLen, 1774);
    check(riseGap == 1280 * 4, "R2 continuous period", riseGap, 5120);
    check(resSign === 1'b0 && int'(resMag) == 4321, "R9 continuous result", resMag, 4321);
    @(negedge clk); contMode = 1'b0;
    ticks(1400);
    check(busy === 1'b0, "R9 stops after mode drop", busy, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CLKS) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CLKS, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule